// File: doc/BRIEF.md
# Bitstream Prefetch Engine

This block feeds a compressed bitstream, byte by byte, to a downstream variable-length decoder. A host CPU programs a buffer start address and a byte count. The engine then reads the buffer from main memory in bursts into a 64-byte on-chip FIFO, and the decoder pulls the bytes out through a valid/ready port.

A new burst is requested only once the FIFO has drained completely. Each burst is as long as the FIFO, or as long as what is left of the buffer if that is less. After every burst the live address register points at the next byte to fetch, and the live count register holds the bytes still to fetch. When the count reaches zero, a sticky done flag is set and an interrupt can be raised. The engine then waits until the host supplies a fresh buffer.

Host registers sit at three offsets. Reads return the register value one clock after `host_sel` is presented.
- Offset 0: the address.
- Offset 1: the count.
- Offset 2: control. Bit 0 is the done flag, which is cleared by writing 1 to it. Bit 1 is the interrupt enable.

Top module: `bsfetch_top`

## Requirements
- R1: After reset, no memory request is made, `out_valid` and `irq` are 0, and the registers at offsets 0, 1 and 2 read as zero.
- R2: `mem_req` is raised only when the count register is nonzero and the FIFO is empty (`out_valid` low). It is never raised while fetched bytes are still waiting for the decoder.
- R3: The FIFO holds 64 bytes. Each burst length `mem_len` is the smaller of 64 and the remaining count, and the FIFO never overflows.
- R4: Once `mem_req` is raised, it stays high with `mem_addr` and `mem_len` unchanged until `mem_gnt` is seen.
- R5: The decoder receives the returned bytes in fetch order. A byte is taken when `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_valid` and `out_data` hold.
- R6: After each burst, the address register (offset 0) holds the start address plus all bytes fetched so far. Each burst request uses that address.
- R7: After each burst, the count register (offset 1) holds the programmed count minus all bytes fetched so far.
- R8: When a burst brings the count to zero, the done flag (offset 2, bit 0) is set. It stays set until 1 is written to that bit.
- R9: `irq` is high exactly when the done flag and the enable bit (offset 2, bit 1) are both 1.
- R10: Writes to offsets 0 and 1 are ignored while a burst is requested or in flight.
- R11: Writing a nonzero count while idle clears the done flag and starts fetching from the address register.
- R12: Bytes still in the FIFO when the count reaches zero keep draining to the decoder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 2 | Host register offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered read data for `host_sel` |
| mem_req | output | 1 | Burst read request |
| mem_gnt | input | 1 | Request accepted |
| mem_addr | output | 32 | Burst start byte address |
| mem_len | output | 7 | Burst length in bytes (1 to 64) |
| mem_rvalid | input | 1 | Returned byte valid |
| mem_rdata | input | 8 | Returned byte |
| out_valid | output | 1 | Byte available to the decoder |
| out_data | output | 8 | Byte to the decoder |
| out_ready | input | 1 | Decoder takes the byte |
| irq | output | 1 | Done flag AND interrupt enable |

## Verification
The engine is driven with several buffers:
- A 150-byte buffer read by an always-ready decoder. It ends in a short 22-byte burst, which separates the burst-length rule from a fixed burst size.
- An exact 64-byte buffer read by an alternating decoder. It checks that the last burst is not split or repeated.
- A 200-byte buffer whose decoder first stalls completely. This shows that no refill starts while the FIFO is full, and it exposes the live address and count between bursts.
- The same 200-byte buffer served slowly, with register writes aimed at the in-flight burst. These must not change the stream.
- A 10-byte buffer left undrained after the count reaches zero, and a 1-byte buffer. These separate the done flag from FIFO occupancy.

// File: rtl/bsfetch_pkg.sv
package bsfetch_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } fetch_st_e;

  localparam logic [1:0] SEL_ADDR  = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;
endpackage

// File: rtl/bsfetch_fifo.sv
module bsfetch_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int PW   = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic [DW-1:0]   din,
  input  logic            pop,
  output logic [DW-1:0]   dout,
  output logic            empty,
  output logic [CNTW-1:0] cnt
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          do_pop;

  assign do_pop = pop && (cnt != '0);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push)   wr_ptr <= wr_ptr + 1'b1;
      if (do_pop) rd_ptr <= rd_ptr + 1'b1;
      if (push && !do_pop)      cnt <= cnt + 1'b1;
      else if (!push && do_pop) cnt <= cnt - 1'b1;
    end
  end

  assign dout  = mem[rd_ptr];
  assign empty = (cnt == '0);
endmodule

// File: rtl/bsfetch_ctrl.sv
module bsfetch_ctrl
  import bsfetch_pkg::*;
#(
  parameter int CW    = 24,
  parameter int DEPTH = 64,
  localparam int LENW = $clog2(DEPTH) + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CW-1:0]   cur_count,
  input  logic            fifo_empty,
  input  logic            hold_off,
  input  logic            mem_gnt,
  input  logic            mem_rvalid,
  output logic            mem_req,
  output logic [LENW-1:0] mem_len,
  output logic            push,
  output logic            burst_done,
  output logic            busy
);
  fetch_st_e       st_q;
  logic [LENW-1:0] len_q;
  logic [LENW-1:0] beats_q;

  assign push       = (st_q == ST_WAIT) && mem_rvalid;
  assign burst_done = push && (beats_q == len_q - LENW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      len_q   <= '0;
      beats_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (cur_count != '0 && fifo_empty && !hold_off) begin
          st_q  <= ST_REQ;
          len_q <= (cur_count >= CW'(DEPTH)) ? LENW'(DEPTH) : cur_count[LENW-1:0];
        end
        ST_REQ: if (mem_gnt) begin
          st_q    <= ST_WAIT;
          beats_q <= '0;
        end
        ST_WAIT: if (mem_rvalid) begin
          beats_q <= beats_q + 1'b1;
          if (burst_done) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req = (st_q == ST_REQ);
  assign mem_len = len_q;
  assign busy    = (st_q != ST_IDLE);
endmodule

// File: rtl/bsfetch_regs.sv
module bsfetch_regs
  import bsfetch_pkg::*;
#(
  parameter int AW   = 32,
  parameter int CW   = 24,
  parameter int HW   = 32,
  parameter int LENW = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            host_we,
  input  logic [1:0]      host_sel,
  input  logic [HW-1:0]   host_wdata,
  output logic [HW-1:0]   host_rdata,
  input  logic            busy,
  input  logic            burst_done,
  input  logic [LENW-1:0] burst_len,
  output logic [AW-1:0]   cur_addr,
  output logic [CW-1:0]   cur_count,
  output logic            irq
);
  logic          flag_q, en_q, flag_d, en_d;
  logic          wr_addr, wr_count, wr_ctrl;
  logic          unused_hi;

  assign unused_hi = ^host_wdata[HW-1:CW];
  assign wr_addr   = host_we && host_sel == SEL_ADDR  && !busy;
  assign wr_count  = host_we && host_sel == SEL_COUNT && !busy;
  assign wr_ctrl   = host_we && host_sel == SEL_CTRL;

  always_comb begin
    flag_d = flag_q;
    en_d   = en_q;
    if (wr_ctrl) begin
      en_d = host_wdata[1];
      if (host_wdata[0]) flag_d = 1'b0;
    end
    if (wr_count && host_wdata[CW-1:0] != '0) flag_d = 1'b0;
    if (burst_done && cur_count == CW'(burst_len)) flag_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr   <= '0;
      cur_count  <= '0;
      flag_q     <= 1'b0;
      en_q       <= 1'b0;
      irq        <= 1'b0;
      host_rdata <= '0;
    end else begin
      if (burst_done) begin
        cur_addr  <= cur_addr + AW'(burst_len);
        cur_count <= cur_count - CW'(burst_len);
      end else begin
        if (wr_addr)  cur_addr  <= host_wdata[AW-1:0];
        if (wr_count) cur_count <= host_wdata[CW-1:0];
      end
      flag_q <= flag_d;
      en_q   <= en_d;
      irq    <= flag_d && en_d;
      case (host_sel)
        SEL_ADDR:  host_rdata <= HW'(cur_addr);
        SEL_COUNT: host_rdata <= HW'(cur_count);
        SEL_CTRL:  host_rdata <= HW'({en_q, flag_q});
        default:   host_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/bsfetch_top.sv
module bsfetch_top #(
  parameter int AW    = 32,
  parameter int CW    = 24,
  parameter int HW    = 32,
  parameter int DEPTH = 64,
  localparam int LENW = $clog2(DEPTH) + 1,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            host_we,
  input  logic [1:0]      host_sel,
  input  logic [HW-1:0]   host_wdata,
  output logic [HW-1:0]   host_rdata,
  output logic            mem_req,
  input  logic            mem_gnt,
  output logic [AW-1:0]   mem_addr,
  output logic [LENW-1:0] mem_len,
  input  logic            mem_rvalid,
  input  logic [7:0]      mem_rdata,
  output logic            out_valid,
  output logic [7:0]      out_data,
  input  logic            out_ready,
  output logic            irq
);
  logic [CW-1:0]   cur_count;
  logic [CNTW-1:0] fifo_cnt;
  logic            fifo_empty, push, burst_done, busy;

  bsfetch_fifo #(.DW(8), .DEPTH(DEPTH)) i_fifo (
    .clk(clk), .rst(rst), .push(push), .din(mem_rdata),
    .pop(out_ready), .dout(out_data), .empty(fifo_empty), .cnt(fifo_cnt)
  );

  bsfetch_ctrl #(.CW(CW), .DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rst(rst), .cur_count(cur_count), .fifo_empty(fifo_empty),
    .hold_off(host_we), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
    .mem_req(mem_req), .mem_len(mem_len), .push(push),
    .burst_done(burst_done), .busy(busy)
  );

  bsfetch_regs #(.AW(AW), .CW(CW), .HW(HW), .LENW(LENW)) i_regs (
    .clk(clk), .rst(rst), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy),
    .burst_done(burst_done), .burst_len(mem_len), .cur_addr(mem_addr),
    .cur_count(cur_count), .irq(irq)
  );

  assign out_valid = !fifo_empty;
endmodule

// File: rtl/bsfetch_chk.sv
module bsfetch_chk #(
  parameter int AW    = 32,
  parameter int HW    = 32,
  parameter int DEPTH = 64,
  parameter int LENW  = 7,
  parameter int CNTW  = 7
) (
  input logic            clk,
  input logic            rst,
  input logic            host_we,
  input logic [1:0]      host_sel,
  input logic [HW-1:0]   host_wdata,
  input logic            mem_req,
  input logic            mem_gnt,
  input logic [AW-1:0]   mem_addr,
  input logic [LENW-1:0] mem_len,
  input logic            mem_rvalid,
  input logic            out_valid,
  input logic [7:0]      out_data,
  input logic            out_ready,
  input logic            irq,
  input logic [CNTW-1:0] fifo_cnt
);
  p_req_when_empty_r2: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !out_valid);

  p_len_range_r3: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_len != '0 && mem_len <= LENW'(DEPTH)));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    fifo_cnt <= CNTW'(DEPTH));

  p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_len)));

  p_out_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_flag_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (host_we && host_sel == 2'd2 && host_wdata[0] && !mem_rvalid) |=> !irq);
endmodule

bind bsfetch_top bsfetch_chk #(
  .AW(AW), .HW(HW), .DEPTH(DEPTH), .LENW(LENW), .CNTW(CNTW)
) i_chk (
  .clk(clk), .rst(rst), .host_we(host_we), .host_sel(host_sel),
  .host_wdata(host_wdata), .mem_req(mem_req), .mem_gnt(mem_gnt),
  .mem_addr(mem_addr), .mem_len(mem_len), .mem_rvalid(mem_rvalid),
  .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
  .irq(irq), .fifo_cnt(fifo_cnt)
);

// File: tb/test_bsfetch_top.sv
module test_bsfetch_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        mem_req, mem_gnt = 1'b0;
  logic [31:0] mem_addr;
  logic [6:0]  mem_len;
  logic        mem_rvalid = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_ready = 1'b0;
  logic        irq;

  bsfetch_top i_bsfetch_top (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  // reference model state
  int  m_addr = 0, m_rem = 0;
  bit  m_done = 0, m_en = 0;
  byte unsigned q[$];
  bit  pending = 0;
  int  blen = 0, beats = 0, hold_cnt = 0, seen_addr = 0, seen_len = 0;
  int  rdy_mode = 0;
  bit  slow = 0;
  int  cyc = 0;

  // host command mailbox
  bit  cmd_valid = 0, cmd_we = 0, rd_wait = 0, rd_done = 0;
  int  cmd_a = 0;
  logic [31:0] cmd_d = '0, rd_val = '0;

  function automatic byte unsigned pat(int a);
    return byte'((a * 13 + (a >> 8) + 7) & 255);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h) at %0t", tag, act, act, exp, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      bit rdy;
      bit busy_now;
      cyc++;
      // R9 / R8: interrupt follows flag and enable
      chk(irq == (m_done && m_en), "R9 irq", int'(irq), int'(m_done && m_en));
      // R5 / R12: delivery in order
      chk(out_valid == (q.size() != 0), "R5 out_valid", int'(out_valid), int'(q.size() != 0));
      case (rdy_mode)
        0: rdy = 1'b1;
        1: rdy = cyc[0];
        2: rdy = 1'b0;
        default: rdy = (cyc % 3 == 0);
      endcase
      if (out_valid && rdy) begin
        if (q.size() == 0) chk(0, "R5 unexpected byte", int'(out_data), -1);
        else begin
          chk(out_data == q[0], "R5/R12 byte order", int'(out_data), int'(q[0]));
          void'(q.pop_front());
        end
      end
      out_ready = rdy;
      // host interface
      host_we = 1'b0;
      if (rd_wait) begin
        rd_val  = host_rdata;
        rd_wait = 0;
        rd_done = 1;
      end
      busy_now = mem_req || pending;
      if (cmd_valid) begin
        host_sel   = cmd_a[1:0];
        host_wdata = cmd_d;
        if (cmd_we) begin
          host_we = 1'b1;
          if (cmd_a == 0 && !busy_now) m_addr = int'(cmd_d);
          if (cmd_a == 1 && !busy_now) begin
            m_rem = int'(cmd_d[23:0]);
            if (cmd_d[23:0] != 0) m_done = 0;
          end
          if (cmd_a == 2) begin
            m_en = cmd_d[1];
            if (cmd_d[0]) m_done = 0;
          end
        end else rd_wait = 1;
        cmd_valid = 0;
      end
      // memory responder
      if (!pending) begin
        mem_gnt    = 1'b0;
        mem_rvalid = 1'b0;
        if (mem_req) begin
          int exp_len;
          exp_len = (m_rem >= 64) ? 64 : m_rem;
          chk(m_rem != 0, "R2 request with zero count", m_rem, 1);
          chk(q.size() == 0 && !out_valid, "R2 request while FIFO holds data", q.size(), 0);
          if (hold_cnt == 0) begin
            seen_addr = int'(mem_addr);
            seen_len  = int'(mem_len);
            chk(int'(mem_addr) == m_addr, "R6 burst address", int'(mem_addr), m_addr);
            chk(int'(mem_len) == exp_len, "R3 burst length", int'(mem_len), exp_len);
          end else begin
            chk(int'(mem_addr) == seen_addr && int'(mem_len) == seen_len,
                "R4 request held stable", int'(mem_addr), seen_addr);
          end
          if (hold_cnt == 2) begin
            mem_gnt  = 1'b1;
            pending  = 1;
            beats    = 0;
            blen     = int'(mem_len);
            hold_cnt = 0;
          end else hold_cnt++;
        end
      end else begin
        bit beat_ok;
        mem_gnt = 1'b0;
        chk(!mem_req, "R4 request dropped after grant", int'(mem_req), 0);
        beat_ok = slow ? (cyc % 4 == 0) : (cyc % 3 != 2);
        if (beat_ok) begin
          mem_rvalid = 1'b1;
          mem_rdata  = pat(m_addr + beats);
          q.push_back(pat(m_addr + beats));
          beats++;
          if (beats == blen) begin
            pending = 0;
            m_addr += blen;
            m_rem  -= blen;
            if (m_rem == 0) m_done = 1;
          end
        end else mem_rvalid = 1'b0;
      end
    end
  end

  task automatic host_wr(int a, logic [31:0] d);
    @(posedge clk);
    cmd_we = 1; cmd_a = a; cmd_d = d; cmd_valid = 1;
    wait (cmd_valid == 0);
  endtask

  task automatic host_rd(int a, output logic [31:0] v);
    @(posedge clk);
    rd_done = 0;
    cmd_we = 0; cmd_a = a; cmd_valid = 1;
    wait (rd_done == 1);
    v = rd_val;
  endtask

  task automatic expect_reg(int a, int exp, string tag);
    logic [31:0] v;
    host_rd(a, v);
    chk(v == exp, tag, int'(v), exp);
  endtask

  task automatic wait_idle();
    int n = 0;
    do begin
      @(posedge clk);
      n++;
    end while (!(m_rem == 0 && !pending && q.size() == 0 && !mem_req) && n < 20000);
    chk(n < 20000, "stream completion timeout", n, 0);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(!mem_req && !out_valid && !irq, "R1 reset outputs", int'({mem_req, out_valid, irq}), 0);
    expect_reg(0, 0, "R1 address after reset");
    expect_reg(1, 0, "R1 count after reset");
    expect_reg(2, 0, "R1 control after reset");

    // 150 bytes, short last burst, always-ready decoder (R3, R6, R7, R8, R9)
    rdy_mode = 0;
    host_wr(2, 32'h2);
    host_wr(0, 32'h100);
    host_wr(1, 150);
    wait_idle();
    expect_reg(0, 32'h196, "R6 address after buffer");
    expect_reg(1, 0, "R7 count after buffer");
    expect_reg(2, 3, "R8 flag set");
    chk(irq, "R9 irq raised", int'(irq), 1);

    // R8: write-1-to-clear
    host_wr(2, 32'h3);
    repeat (2) @(posedge clk);
    chk(!irq, "R8 flag cleared", int'(irq), 0);
    expect_reg(2, 2, "R8 flag cleared read");

    // exact 64 bytes, alternating decoder, interrupt disabled (R9, R11)
    rdy_mode = 1;
    host_wr(2, 32'h0);
    host_wr(0, 32'h2000);
    host_wr(1, 64);
    wait_idle();
    expect_reg(2, 1, "R9 flag without enable");
    chk(!irq, "R9 irq masked", int'(irq), 0);

    // stalled decoder: no refill while FIFO full, live registers (R2, R6, R7)
    rdy_mode = 2;
    host_wr(2, 32'h2);
    host_wr(0, 32'h40);
    host_wr(1, 200);
    repeat (200) @(posedge clk);
    expect_reg(0, 32'h80, "R6 live address mid-buffer");
    expect_reg(1, 136, "R7 live count mid-buffer");
    chk(out_valid && !mem_req, "R2 no refill while full", int'(mem_req), 0);

    // writes during an in-flight burst are ignored (R10)
    slow = 1;
    rdy_mode = 1;
    n = 0;
    do begin @(posedge clk); n++; end while (!mem_req && n < 2000);
    host_wr(1, 5);
    host_wr(0, 32'h0);
    wait_idle();
    expect_reg(0, 32'h108, "R10 address unaffected");
    expect_reg(1, 0, "R10 count unaffected");
    slow = 0;

    // bytes drain after count hits zero (R12)
    host_wr(2, 32'h3);
    rdy_mode = 2;
    host_wr(0, 32'h300);
    host_wr(1, 10);
    repeat (60) @(posedge clk);
    chk(irq && out_valid, "R12 flag set while bytes remain", int'({irq, out_valid}), 3);
    rdy_mode = 0;
    wait_idle();
    chk(!out_valid, "R12 all bytes drained", int'(out_valid), 0);

    // single-byte buffer, sparse decoder (R3, R11)
    host_wr(2, 32'h3);
    rdy_mode = 3;
    host_wr(0, 32'h7FF);
    host_wr(1, 1);
    wait_idle();
    expect_reg(0, 32'h800, "R11 single byte address");
    expect_reg(2, 3, "R11 single byte flag");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule